// File: doc/BRIEF.md
# ADC Serial Result Shifter

This block is the serial output stage of a converter. While the active-low chip select is held low it shifts one 16-position frame out on a single data line. The line is modelled as a data value `sdo` plus an enable `sdo_oe`, and the line counts as high-impedance whenever the enable is low. A parallel word sits behind the frame. It is either a 12-bit conversion result, which is sent first and followed by padding zeros, or a 12-bit register readback, which has padding zeros in front of it. `frame_sel` picks the kind.

The serial pins `cs_n`, `fs` and `sclk` are oversampled by the block clock through short synchronizer chains. The level of `fs` at the moment chip select falls sets the timing mode for the whole frame. With `fs` high the frame is in plain mode: the first bit appears right after chip select falls and each later bit is launched on a rising serial-clock edge. With `fs` low the frame is in frame-sync mode: the line stays off until a falling serial-clock edge finds `fs` low, and from then on each later bit is launched on a falling edge. The word and the frame kind are captured when chip select falls. A frame always starts at its first bit and can be abandoned at any time by raising chip select.

Top module: `adc_result_shifter`

## Requirements
- R1: While the synchronized chip select is high, `sdo_oe` is low from the next block-clock cycle on, and serial-clock or frame-sync activity does not raise it.
- R2: If `fs` is high (1) when chip select falls, `sdo_oe` rises a few block-clock cycles after the fall, with no serial-clock edge needed, and `sdo` shows frame position 15.
- R3: In plain mode each rising `sclk` edge moves `sdo` to the next lower frame position, and falling edges leave `sdo` unchanged.
- R4: If `fs` is low (0) when chip select falls, `sdo_oe` stays low until the first falling `sclk` edge at which `fs` is low, and then `sdo` shows frame position 15.
- R5: In frame-sync mode each later falling `sclk` edge moves `sdo` to the next lower position, and rising edges leave `sdo` unchanged.
- R6: A data frame (`frame_sel`=0) carries `result_word` bit 11 down to bit 0 in positions 15 down to 4, then zeros in positions 3 to 0, sent MSB first.
- R7: A register frame (`frame_sel`=1) carries zeros in positions 15 to 12, then `reg_word` bit 11 down to bit 0 in positions 11 down to 0.
- R8: The launch edge that follows position 0 drops `sdo_oe`, and it stays low until chip select rises, even under further serial-clock edges. No frame shows more than 16 positions.
- R9: The word and the frame kind are taken when chip select falls. Changes to `result_word`, `reg_word` or `frame_sel` during the frame do not alter it.
- R10: Raising chip select before position 0 turns `sdo_oe` off at once. The next frame starts again at position 15 with freshly captured data.
- R11: Whenever `sdo_oe` is low, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; frame window |
| fs | input | 1 | Frame-sync pin; its level at chip-select fall picks the mode |
| sclk | input | 1 | Serial clock from the host |
| result_word | input | 12 | Conversion or FIFO result to send |
| reg_word | input | 12 | Configuration register content to send |
| frame_sel | input | 1 | 0 = data frame, 1 = register readback frame |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable of the data line; low means high-impedance |

## Verification
Some properties are checked on every cycle. The line is off whenever chip select is high, and `sdo` is zero whenever the line is off. The first bit only appears after the edge that belongs to the mode, and `sdo` stays put between launch edges. The padding positions of both frame kinds are zero, and no frame goes past 16 positions. The actual bit values against the captured word can only be shown by the bench's scenarios: both frame kinds in both modes, inputs changed during a frame, an aborted frame followed by a clean restart, and serial-clock activity while chip select is high.

// File: rtl/adc_result_shifter_pkg.sv
package adc_result_shifter_pkg;

  typedef enum logic {
    TIMING_PLAIN = 1'b0,
    TIMING_FSYNC = 1'b1
  } timing_e;

  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_REG  = 1'b1
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

endpackage

// File: rtl/adc_result_shifter_sync.sv
module adc_result_shifter_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RESET_VAL;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

endmodule

// File: rtl/adc_result_shifter_fmt.sv
module adc_result_shifter_fmt
  import adc_result_shifter_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic [DATA_W-1:0]  result_word,
  input  logic [DATA_W-1:0]  reg_word,
  input  kind_e              kind,
  output logic [FRAME_W-1:0] frame
);

  localparam int PAD_W = FRAME_W - DATA_W;

  // R6: result leads and zeros trail; R7: zeros lead and register trails
  always_comb begin
    case (kind)
      KIND_REG: frame = {{PAD_W{1'b0}}, reg_word};
      default:  frame = {result_word, {PAD_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/adc_result_shifter_ctrl.sv
module adc_result_shifter_ctrl
  import adc_result_shifter_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_lvl,
  input  logic               cs_fall,
  input  logic               fs_lvl,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic [FRAME_W-1:0] frame_in,
  input  kind_e              kind_in,
  output timing_e            timing_q,
  output kind_e              kind_q,
  output logic               sdo,
  output logic               sdo_oe
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

  state_e             state;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   sent;
  logic               launch;

  // R3/R5: the launch edge depends on the mode latched at the frame start
  assign launch = (timing_q == TIMING_FSYNC) ? sclk_fall : sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      sent     <= '0;
      timing_q <= TIMING_PLAIN;
      kind_q   <= KIND_DATA;
    end else if (cs_lvl) begin
      // R1/R10: chip select high ends any frame at once
      state <= ST_IDLE;
      sent  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cs_fall) begin
            // R9: word and kind are frozen here
            shreg  <= frame_in;
            kind_q <= kind_in;
            sent   <= '0;
            if (fs_lvl) begin
              timing_q <= TIMING_PLAIN;   // R2
              state    <= ST_SHIFT;
            end else begin
              timing_q <= TIMING_FSYNC;   // R4
              state    <= ST_ARM;
            end
          end
        end
        ST_ARM: begin
          if (sclk_fall && !fs_lvl) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (launch) begin
            if (sent == LAST_POS) begin
              state <= ST_DONE;           // R8
            end else begin
              sent  <= sent + 1'b1;
              shreg <= {shreg[FRAME_W-2:0], 1'b0};
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign sdo_oe = (state == ST_SHIFT);
  assign sdo    = sdo_oe & shreg[FRAME_W-1];   // R11

endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter
  import adc_result_shifter_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              fs,
  input  logic              sclk,
  input  logic [DATA_W-1:0] result_word,
  input  logic [DATA_W-1:0] reg_word,
  input  logic              frame_sel,
  output logic              sdo,
  output logic              sdo_oe
);

  logic cs_lvl, cs_rise, cs_fall;
  logic fs_lvl, fs_rise, fs_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic unused_edges;
  logic [FRAME_W-1:0] frame;
  kind_e   kind_in;
  kind_e   kind_q;
  timing_e timing_q;

  assign unused_edges = ^{cs_rise, fs_rise, fs_fall, sclk_lvl};
  assign kind_in      = frame_sel ? KIND_REG : KIND_DATA;

  adc_result_shifter_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );

  adc_result_shifter_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_fs (
    .clk(clk), .rst_n(rst_n), .din(fs),
    .level(fs_lvl), .rise(fs_rise), .fall(fs_fall)
  );

  adc_result_shifter_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .din(sclk),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  adc_result_shifter_fmt #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_fmt (
    .result_word(result_word),
    .reg_word   (reg_word),
    .kind       (kind_in),
    .frame      (frame)
  );

  adc_result_shifter_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (cs_lvl),
    .cs_fall  (cs_fall),
    .fs_lvl   (fs_lvl),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .frame_in (frame),
    .kind_in  (kind_in),
    .timing_q (timing_q),
    .kind_q   (kind_q),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

endmodule

// File: rtl/adc_result_shifter_chk.sv
module adc_result_shifter_chk
  import adc_result_shifter_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16
) (
  input logic    clk,
  input logic    rst_n,
  input logic    cs_lvl,
  input logic    cs_fall,
  input logic    fs_lvl,
  input logic    sclk_rise,
  input logic    sclk_fall,
  input timing_e timing_q,
  input kind_e   kind_q,
  input logic    sdo,
  input logic    sdo_oe
);

  localparam int PAD_W = FRAME_W - DATA_W;
  localparam int IDX_W = $clog2(FRAME_W) + 1;

  logic             launch;
  logic [IDX_W-1:0] pos;

  assign launch = (timing_q == TIMING_FSYNC) ? sclk_fall : sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (!sdo_oe) pos <= '0;
    else if (launch)  pos <= pos + 1'b1;
  end

  p_off_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> !sdo_oe);

  p_plain_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_oe) && timing_q == TIMING_PLAIN) |-> ($past(cs_fall) && $past(fs_lvl)));

  p_hold_between_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(launch)) |-> $stable(sdo));

  p_fsync_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_oe) && timing_q == TIMING_FSYNC) |-> ($past(sclk_fall) && !$past(fs_lvl)));

  p_data_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && kind_q == KIND_DATA && pos >= IDX_W'(DATA_W)) |-> !sdo);

  p_reg_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && kind_q == KIND_REG && pos < IDX_W'(PAD_W)) |-> !sdo);

  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (pos < IDX_W'(FRAME_W)));

  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

endmodule

bind adc_result_shifter adc_result_shifter_chk #(
  .DATA_W (DATA_W),
  .FRAME_W(FRAME_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_lvl   (cs_lvl),
  .cs_fall  (cs_fall),
  .fs_lvl   (fs_lvl),
  .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall),
  .timing_q (timing_q),
  .kind_q   (kind_q),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe)
);

// File: tb/tb_adc_result_shifter.sv
module tb_adc_result_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        fs = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] result_word = '0;
  logic [11:0] reg_word = '0;
  logic        frame_sel = 1'b0;
  logic        sdo;
  logic        sdo_oe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_shifter dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk),
    .result_word(result_word), .reg_word(reg_word), .frame_sel(frame_sel),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  function automatic logic [15:0] expect_frame(input logic [11:0] r, input logic [11:0] g, input bit k);
    return k ? {4'b0000, g} : {r, 4'b0000};
  endfunction

  task automatic check_bit(input logic [15:0] f, input int i, input string req);
    check(sdo_oe === 1'b1, {req, " oe"}, int'(sdo_oe), 1);
    check(sdo === f[i], req, int'(sdo), int'(f[i]));
  endtask

  task automatic check_off(input string req);
    check(sdo_oe === 1'b0, {req, " oe"}, int'(sdo_oe), 0);
    check(sdo === 1'b0, "R11 sdo low when off", int'(sdo), 0);
  endtask

  // Plain mode frame; optional scramble of inputs after capture (R9)
  task automatic t_plain(input logic [11:0] r, input logic [11:0] g, input bit k, input bit scramble);
    logic [15:0] f = expect_frame(r, g, k);
    result_word = r; reg_word = g; frame_sel = k; fs = 1'b1; sclk = 1'b0;
    settle();
    cs_n = 1'b0;
    settle();
    if (scramble) begin
      result_word = ~r; reg_word = ~g; frame_sel = ~k;
    end
    check_bit(f, 15, k ? "R2/R7 plain first" : "R2/R6 plain first");
    for (int i = 14; i >= 0; i--) begin
      sclk = 1'b1; settle();
      check_bit(f, i, scramble ? "R9 capture" : (k ? "R3/R7 rise launch" : "R3/R6 rise launch"));
      sclk = 1'b0; settle();
      check(sdo === f[i], "R3 falling edge ignored", int'(sdo), int'(f[i]));
    end
    sclk = 1'b1; settle();
    check_off("R8 off after last position");
    sclk = 1'b0; settle();
    sclk = 1'b1; settle();
    check_off("R8 stays off");
    sclk = 1'b0;
    cs_n = 1'b1; settle();
    check_off("R1 off with cs high");
  endtask

  task automatic t_fsync(input logic [11:0] r, input logic [11:0] g, input bit k);
    logic [15:0] f = expect_frame(r, g, k);
    result_word = r; reg_word = g; frame_sel = k; sclk = 1'b1;
    fs = 1'b0;
    settle();
    cs_n = 1'b0;
    settle();
    check_off("R4 off before fs detected");
    sclk = 1'b0; settle();
    check_bit(f, 15, k ? "R4/R7 fsync first" : "R4/R6 fsync first");
    fs = 1'b1;
    for (int i = 14; i >= 0; i--) begin
      sclk = 1'b1; settle();
      check(sdo === f[i+1], "R5 rising edge ignored", int'(sdo), int'(f[i+1]));
      sclk = 1'b0; settle();
      check_bit(f, i, k ? "R5/R7 fall launch" : "R5/R6 fall launch");
    end
    sclk = 1'b1; settle();
    sclk = 1'b0; settle();
    check_off("R8 off after last position");
    cs_n = 1'b1; sclk = 1'b1; settle();
    check_off("R1 off with cs high");
    sclk = 1'b0; settle();
  endtask

  task automatic t_abort_restart();
    logic [15:0] f = expect_frame(12'h6B3, 12'h000, 1'b0);
    result_word = 12'h6B3; frame_sel = 1'b0; fs = 1'b1; sclk = 1'b0;
    settle();
    cs_n = 1'b0; settle();
    for (int i = 14; i >= 10; i--) begin
      sclk = 1'b1; settle();
      sclk = 1'b0; settle();
    end
    check_bit(f, 10, "R10 before abort");
    cs_n = 1'b1; settle();
    check_off("R10 abort");
    t_plain(12'h9E4, 12'h123, 1'b0, 1'b0);
    check(1'b1, "R10 restart done", 0, 0);
  endtask

  task automatic t_idle_activity();
    cs_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      fs = ~fs; settle();
      sclk = 1'b1; settle();
      check_off("R1 clock activity with cs high");
      sclk = 1'b0; settle();
    end
    fs = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_off("R1 reset state");
    rst_n = 1'b1;
    settle();
    check_off("R1 after reset");
    t_idle_activity();
    t_plain(12'hA5C, 12'h3F1, 1'b0, 1'b0);
    t_plain(12'hA5C, 12'h3F1, 1'b1, 1'b0);
    t_fsync(12'hFFF, 12'h555, 1'b0);
    t_fsync(12'h0F0, 12'h801, 1'b1);
    t_plain(12'h5A7, 12'hC3C, 1'b0, 1'b1);
    t_plain(12'h5A7, 12'hC3C, 1'b1, 1'b1);
    t_abort_restart();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule